// File: doc/BRIEF.md
# AC97 Output Frame Serializer

The block turns one stereo PCM sample pair and an optional codec register write into a 256-bit AC97 output frame. It shifts that frame out one bit per cycle of the codec's bit clock and drives the frame sync line. It runs entirely in the bit-clock domain. Output changes on the rising edge, so the codec can sample it on the falling edge.

The serializer stays silent until the codec reports ready. When the ready flag is first seen, the serializer loads a frame and raises sync on the same edge. From then on it sends frames back to back. On each load edge it captures the PCM words and the command inputs. In the following cycle it pulses a request strobe, so the client can present the contents of the next frame.

Top module: `ac97_frame_tx`

## Requirements
- R1: Once running, sync rises exactly once every 256 bit clocks, and each frame carries 256 serial bits.
- R2: Sync stays high for exactly 16 consecutive bit clocks per frame.
- R3: Sync rises in the cycle before the first tag bit, and the load happens on that same edge. Frame bit 255 (tag bit 15) is on `sdata_out` in the cycle after sync rises. The remaining bits follow MSB first, one per cycle, in the order tag slot (16 bits) and then slots 1 to 12 (20 bits each).
- R4: The tag slot is as follows. Bit 15 is 1 (frame valid). Bits 14 and 13 equal the captured `cmd_valid` (slots 1 and 2 valid). Bits 12 and 11 are 1 (slots 3 and 4 valid). Bits 10 down to 0 are 0.
- R5: With a command, slot 1 has bit 19 = 0 (write), the 7-bit address in bits 18:12, and 0 in bits 11:0.
- R6: With a command, slot 2 has the 16-bit command data in bits 19:4 and 0 in bits 3:0.
- R7: Slot 3 is the left PCM word and slot 4 is the right PCM word. Slots 5 to 12 are all zero.
- R8: Until `codec_rdy` has been seen high, `sync`, `sdata_out` and `sample_req` stay low.
- R9: PCM and command inputs are captured on the edge where sync rises. `sample_req` is high for exactly the one cycle in which sync has just risen.
- R10: After the first frame starts, frames continue back to back even if `codec_rdy` later falls. Only reset stops them.
- R11: While `rst` is high and after it, until ready, all outputs are 0.
- R12: When the captured `cmd_valid` is 0, slots 1 and 2 are all zero and tag bits 14 and 13 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Codec-supplied bit clock |
| rst | input | 1 | Synchronous active-high reset, bit-clock domain |
| codec_rdy | input | 1 | Codec ready indication |
| pcm_left | input | 20 | Left PCM word for slot 3 |
| pcm_right | input | 20 | Right PCM word for slot 4 |
| cmd_addr | input | 7 | Register address for slot 1 |
| cmd_data | input | 16 | Register data for slot 2 |
| cmd_valid | input | 1 | Command present in this frame |
| sdata_out | output | 1 | Serial frame data, MSB first |
| sync | output | 1 | Frame sync, 16 clocks high per frame |
| sample_req | output | 1 | One-cycle strobe after each frame load |

## Verification
The assertions assume that reset is held for at least one edge before activity. They also assume that the sync window counts run from a reset or idle state, so the past values they look back on are never from before reset. The stimulus changes inputs only on falling edges. It holds each frame's contents stable from the request strobe up to the next load edge. It raises ready once and later lowers it while frames are in flight, so the no-stop rule is exercised. The sync-width properties look back at most 17 cycles, and a frame lasts longer than that, so no window spans a reset.

// File: rtl/ac97_tx_pkg.sv
package ac97_tx_pkg;
   localparam int TAG_W    = 16;
   localparam int SLOT_W   = 20;
   localparam int N_SLOTS  = 12;
   localparam int FRAME_W  = TAG_W + N_SLOTS * SLOT_W;
   localparam int SYNC_LEN = TAG_W;
   localparam int CNT_W    = $clog2(FRAME_W);
   localparam int ADDR_MAX = 7;
   localparam int DATA_MAX = 16;

   typedef logic [SLOT_W-1:0] slot_t;
   typedef logic [TAG_W-1:0]  tag_t;

   function automatic tag_t make_tag(input logic cmd_ok);
      tag_t t;
      t      = '0;
      t[15]  = 1'b1;
      t[14]  = cmd_ok;
      t[13]  = cmd_ok;
      t[12]  = 1'b1;
      t[11]  = 1'b1;
      return t;
   endfunction
endpackage

// File: rtl/ac97_frame_timer.sv
module ac97_frame_timer
   import ac97_tx_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic codec_rdy,
   output logic load_o,
   output logic sync_o,
   output logic req_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic             run_q, sync_q, req_q;
   logic [CNT_W-1:0] cnt_q, cnt_nx;

   assign cnt_nx = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   assign load_o = run_q ? (cnt_q == LAST) : codec_rdy;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         sync_q <= 1'b0;
         req_q  <= 1'b0;
      end else if (!run_q) begin
         if (codec_rdy) begin
            run_q  <= 1'b1;
            cnt_q  <= '0;
            sync_q <= 1'b1;
            req_q  <= 1'b1;
         end
      end else begin
         cnt_q  <= cnt_nx;
         sync_q <= (int'(cnt_nx) < SYNC_LEN);
         req_q  <= (cnt_nx == '0);
      end
   end

   assign sync_o = sync_q;
   assign req_o  = req_q;

   // R2: sync width is exactly the tag length
   assert_sync_len_R2: assert property (@(posedge clk) disable iff (rst)
      $fell(sync_q) |-> ($past(sync_q, 16) && !$past(sync_q, 17)));
   // R1: a new frame starts right after the last bit position
   assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (rst)
      (run_q && cnt_q == LAST) |=> $rose(sync_q));
   // R9: request strobe only in the cycle sync has just risen
   assert_req_at_rise_R9: assert property (@(posedge clk) disable iff (rst)
      req_q |-> $rose(sync_q));
   // R8: quiet before ready
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      !run_q |-> (!sync_q && !req_q));
endmodule

// File: rtl/ac97_frame_build.sv
module ac97_frame_build
   import ac97_tx_pkg::*;
#(
   parameter int PCM_W  = 20,
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16
) (
   input  logic [PCM_W-1:0]  pcm_left,
   input  logic [PCM_W-1:0]  pcm_right,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              cmd_valid,
   output logic [FRAME_W-1:0] frame_o
);
   slot_t left_s, right_s;
   slot_t slot_v [1:N_SLOTS];
   logic [ADDR_MAX-1:0] addr7;
   logic [DATA_MAX-1:0] data16;

   if (PCM_W > SLOT_W || PCM_W < 1)        $error("PCM_W out of range");
   if (ADDR_W > ADDR_MAX || ADDR_W < 1)    $error("ADDR_W out of range");
   if (DATA_W > DATA_MAX || DATA_W < 1)    $error("DATA_W out of range");

   if (PCM_W == SLOT_W) begin : g_pcm_full
      assign left_s  = pcm_left;
      assign right_s = pcm_right;
   end else begin : g_pcm_pad
      assign left_s  = {pcm_left,  {(SLOT_W-PCM_W){1'b0}}};
      assign right_s = {pcm_right, {(SLOT_W-PCM_W){1'b0}}};
   end

   if (ADDR_W == ADDR_MAX) begin : g_addr_full
      assign addr7 = cmd_addr;
   end else begin : g_addr_ext
      assign addr7 = {{(ADDR_MAX-ADDR_W){1'b0}}, cmd_addr};
   end

   if (DATA_W == DATA_MAX) begin : g_data_full
      assign data16 = cmd_data;
   end else begin : g_data_ext
      assign data16 = {{(DATA_MAX-DATA_W){1'b0}}, cmd_data};
   end

   always_comb begin
      for (int i = 1; i <= N_SLOTS; i++) slot_v[i] = '0;
      if (cmd_valid) begin
         slot_v[1] = {1'b0, addr7, 12'h000};
         slot_v[2] = {data16, 4'h0};
      end
      slot_v[3] = left_s;
      slot_v[4] = right_s;
   end

   assign frame_o[FRAME_W-1 -: TAG_W] = make_tag(cmd_valid);
   for (genvar s = 1; s <= N_SLOTS; s++) begin : g_slot
      assign frame_o[FRAME_W-TAG_W-1-(s-1)*SLOT_W -: SLOT_W] = slot_v[s];
   end
endmodule

// File: rtl/ac97_bit_shifter.sv
module ac97_bit_shifter
   import ac97_tx_pkg::*;
(
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_i,
   output logic               sdo_o
);
   logic [FRAME_W-1:0] sh_q;
   logic               sdo_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q  <= '0;
         sdo_q <= 1'b0;
      end else begin
         sdo_q <= sh_q[FRAME_W-1];
         if (load) sh_q <= frame_i;
         else      sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
      end
   end

   assign sdo_o = sdo_q;

   // R3: the loaded frame's first bit is on the line one edge after the load
   assert_first_bit_R3: assert property (@(posedge clk) disable iff (rst)
      load |=> ##1 (sdo_q == $past(frame_i[FRAME_W-1], 2)));
endmodule

// File: rtl/ac97_frame_tx.sv
module ac97_frame_tx
   import ac97_tx_pkg::*;
#(
   parameter int PCM_W  = 20,
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16
) (
   input  logic              bit_clk,
   input  logic              rst,
   input  logic              codec_rdy,
   input  logic [PCM_W-1:0]  pcm_left,
   input  logic [PCM_W-1:0]  pcm_right,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              cmd_valid,
   output logic              sdata_out,
   output logic              sync,
   output logic              sample_req
);
   logic               load;
   logic [FRAME_W-1:0] frame;

   ac97_frame_timer u_timer (
      .clk       (bit_clk),
      .rst       (rst),
      .codec_rdy (codec_rdy),
      .load_o    (load),
      .sync_o    (sync),
      .req_o     (sample_req)
   );

   ac97_frame_build #(
      .PCM_W  (PCM_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_build (
      .pcm_left  (pcm_left),
      .pcm_right (pcm_right),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data),
      .cmd_valid (cmd_valid),
      .frame_o   (frame)
   );

   ac97_bit_shifter u_shift (
      .clk     (bit_clk),
      .rst     (rst),
      .load    (load),
      .frame_i (frame),
      .sdo_o   (sdata_out)
   );

   // R4: frame-valid tag bit leads every frame
   assert_valid_tag_R4: assert property (@(posedge bit_clk) disable iff (rst)
      $rose(sync) |=> sdata_out);
endmodule

// File: tb/sim_ac97_frame_tx.sv
module sim_ac97_frame_tx;
   localparam int NF = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        codec_rdy = 1'b0;
   logic [19:0] pcm_left = '0, pcm_right = '0;
   logic [6:0]  cmd_addr = '0;
   logic [15:0] cmd_data = '0;
   logic        cmd_valid = 1'b0;
   logic        sdata_out, sync, sample_req;

   int checks = 0, fails = 0;
   int pushed = 0, framesdone = 0;
   logic [255:0] expq[$];

   always #4 clk = ~clk;

   ac97_frame_tx u0 (
      .bit_clk(clk), .rst(rst), .codec_rdy(codec_rdy),
      .pcm_left(pcm_left), .pcm_right(pcm_right),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
      .sdata_out(sdata_out), .sync(sync), .sample_req(sample_req)
   );

   task automatic chk(input bit ok, input string req, input logic [255:0] act,
                      input logic [255:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected frame from the requirement text (R4..R7, R12)
   function automatic logic [255:0] exp_frame(input logic [19:0] l, input logic [19:0] r,
                                              input logic [6:0] a, input logic [15:0] d,
                                              input logic v);
      logic [255:0] f;
      f = '0;
      f[255] = 1'b1; f[254] = v; f[253] = v; f[252] = 1'b1; f[251] = 1'b1;
      if (v) begin
         f[239:220] = {1'b0, a, 12'h000};
         f[219:200] = {d, 4'h0};
      end
      f[199:180] = l;
      f[179:160] = r;
      return f;
   endfunction

   // driver: sets the contents of frame i and pushes its expectation
   task automatic apply(input int i);
      logic [19:0] l, r; logic [6:0] a; logic [15:0] d; logic v;
      case (i)
         0: begin l = 20'h12345; r = 20'hFEDCB; a = 7'h02; d = 16'h8000; v = 1; end
         1: begin l = 20'hFFFFF; r = 20'h00000; a = 7'h55; d = 16'hFFFF; v = 0; end
         2: begin l = 20'h00000; r = 20'hFFFFF; a = 7'h7F; d = 16'hFFFF; v = 1; end
         3: begin l = 20'hAAAAA; r = 20'h55555; a = 7'h3C; d = 16'h1234; v = 0; end
         4: begin l = 20'h80001; r = 20'h00001; a = 7'h00; d = 16'h0000; v = 1; end
         5: begin l = 20'h0F0F0; r = 20'hF0F0F; a = 7'h18; d = 16'h0F0F; v = 1; end
         6: begin l = 20'h00001; r = 20'h80000; a = 7'h2A; d = 16'hA5A5; v = 1; end
         default: begin l = 20'h3C3C3; r = 20'hC3C3C; a = 7'h01; d = 16'h0001; v = 0; end
      endcase
      pcm_left = l; pcm_right = r; cmd_addr = a; cmd_data = d; cmd_valid = v;
      expq.push_back(exp_frame(l, r, a, d, v));
      pushed++;
   endtask

   always @(negedge clk) begin
      if (!rst && sample_req && pushed < NF) apply(pushed);
   end

   // monitor
   logic         prev_sync = 1'b0;
   bit           collecting = 0;
   int           bidx = 0, synccnt = 0, risegap = 0, rises = 0;
   int           idle_hits = 0, req_bad = 0;
   bit           idle_win = 0;
   logic [255:0] cap;

   always @(negedge clk) begin
      logic [255:0] e;
      if (idle_win && (sync || sdata_out || sample_req)) idle_hits++;
      if (!rst) begin
         if (collecting) begin
            cap[255 - bidx] = sdata_out;
            bidx++;
            if (bidx == 256) begin
               collecting = 0;
               if (expq.size() > 0 && framesdone < NF) begin
                  e = expq.pop_front();
                  chk(cap[255:240] == e[255:240], "R4 tag", cap[255:240], e[255:240]);
                  chk(cap[239:220] == e[239:220], e[254] ? "R5 slot1" : "R12 slot1",
                      cap[239:220], e[239:220]);
                  chk(cap[219:200] == e[219:200], e[254] ? "R6 slot2" : "R12 slot2",
                      cap[219:200], e[219:200]);
                  chk(cap[199:160] == e[199:160], "R7 pcm slots", cap[199:160], e[199:160]);
                  chk(cap[159:0] == '0, "R7 zero slots", cap[159:0], '0);
                  chk(cap == e, "R3 whole frame order", cap, e);
                  framesdone++;
               end
            end
         end
         if (sync && !prev_sync) begin
            if (rises > 0)
               chk(risegap == 256, "R1 frame period", 256'(risegap), 256'd256);
            rises++; risegap = 0;
            collecting = 1; bidx = 0;
         end
         if ((sync && !prev_sync) != sample_req) req_bad++;
         if (!sync && prev_sync)
            chk(synccnt == 16, "R2 sync width", 256'(synccnt), 256'd16);
         synccnt = sync ? synccnt + 1 : 0;
         risegap++;
      end
      prev_sync = sync;
   end

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            chk({sync, sdata_out, sample_req} == 3'b000, "R11 reset outputs",
                256'({sync, sdata_out, sample_req}), 256'd0);
            rst = 1'b0;
            apply(0);
            idle_win = 1;
            repeat (300) @(negedge clk);
            idle_win = 0;
            chk(idle_hits == 0, "R8 quiet before ready", 256'(idle_hits), 256'd0);
            codec_rdy = 1'b1;
            wait (framesdone >= 3);
            @(negedge clk);
            codec_rdy = 1'b0;   // R10: frames must keep coming
            wait (framesdone >= NF);
            chk(framesdone == NF, "R10 continues after ready drops",
                256'(framesdone), 256'(NF));
            chk(req_bad == 0, "R9 request strobe timing", 256'(req_bad), 256'd0);
         end
         begin
            repeat (20000) @(posedge clk);
            fails++; checks++;
            $display("FAIL watchdog R1 actual=timeout expected=done");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule